// File: doc/BRIEF.md
# Banked Command Decoder

This block is the command front end of an associative memory device. Each cycle in which `cmdValid` is high delivers one 16-bit command word. Unless an earlier word is still waiting for its second word, the word is read as an instruction: its top four bits select the operation. The block produces one-cycle memory write and read strobes with the access address. It also keeps two banks of configuration state, a foreground and a background bank. Each bank holds a control word and an address register, and two instructions switch between the banks.

A memory instruction with its address flag set takes two command cycles. The second word supplies the address, and the access completes there. After every access the active address register moves by the step set in the active control word. Writing a control word whose top bit is clear performs a soft reset of the whole block. The compare array and the match and full flag chain sit outside this block. It only raises a compare request whenever a control word is stored.

Top module: `cmd_front`

## Requirements
- R1: After `rstN` is released the foreground bank is active (`activeBank`=0), both banks hold control 0 and address 0, and every strobe output is low.
- R2: Instruction bits 15:12 select the operation: 0x1 makes the foreground bank active and 0x2 makes the background bank active. The `activeCtl` and `activeAddr` outputs then show the selected bank's registers.
- R3: Opcode 0x3 makes the next command word a control value. If bit 15 of that word is 1, bits 14:0 are stored into the active bank only, and `cmpReq` pulses in the cycle after that word.
- R4: A control value with bit 15 equal to 0 ignores its other bits. It returns both banks, the bank selection and the decoder state to the R1 state, and it pulses `softRst` instead of `cmpReq`.
- R5: Opcode 0x4 pulses `rdValid` one cycle later, with `rdData` equal to the active control word. Bit 15 of any control word read is always 0.
- R6: Opcode 0x5 (write) or 0x6 (read) with bit 11 equal to 0 pulses `memWr` or `memRd` one cycle later, with `memAddr` equal to the active address register.
- R7: Opcode 0x5 or 0x6 with bit 11 equal to 1 produces no strobe on that word. The low `ADDR_W` bits of the next command word, whatever its top bits, become the access address, and the strobe follows that word by one cycle.
- R8: After each access the active bank's address register becomes the access address plus 1 when control bits 3:2 are 01, minus 1 when they are 10, and unchanged when they are 00 or 11. The result wraps modulo 2^`ADDR_W`.
- R9: Once the address word of a two-cycle instruction has been used, the next command word is decoded as an instruction again.
- R10: Opcodes 0x0 and 0x7 to 0xF, bit 11 on non-memory opcodes, and cycles with `cmdValid` low change no state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word present this cycle |
| cmdData | input | 16 | Command word |
| memWr | output | 1 | Memory write strobe |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | ADDR_W | Address of the current access |
| rdValid | output | 1 | Control readback valid |
| rdData | output | 16 | Control readback value |
| cmpReq | output | 1 | Compare request after a control store |
| softRst | output | 1 | Soft reset pulse |
| activeBank | output | 1 | 0 foreground, 1 background |
| activeCtl | output | 16 | Active control word, bit 15 reads 0 |
| activeAddr | output | ADDR_W | Active address register |

## Verification
Two things meet in one clock edge in the two-cycle access: the address word is loaded and the post-access step is applied to it. The bench sweeps every load value against all four step settings. It checks `memAddr` against the loaded value and `activeAddr` against the value after the step, including wrap at both ends. A following plain read confirms that the stepped address is the one used. Soft reset issued while the background bank is active is judged in the same way. Both banks and the bank selection must read back as their reset values together.

// File: rtl/cmd_front_pkg.sv
package cmd_front_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_SELFG = 4'h1,
    OP_SELBG = 4'h2,
    OP_WRCTL = 4'h3,
    OP_RDCTL = 4'h4,
    OP_WRMEM = 4'h5,
    OP_RDMEM = 4'h6
  } opcode_e;

  localparam int OP_MSB    = 15;
  localparam int OP_LSB    = 12;
  localparam int ADDR_FLAG = 11;
  localparam int CTL_W     = 15;

  typedef struct packed {
    logic selFg;
    logic selBg;
    logic ctlWr;
    logic ctlRd;
    logic memWr;
    logic memRd;
    logic addrLoad;
  } strobe_t;

endpackage

// File: rtl/cmd_front_ctrl.sv
module cmd_front_ctrl
  import cmd_front_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdData,
  output strobe_t     stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CTL} state_e;

  state_e  state, nextState;
  logic    pendWrite, nextPendWrite;
  opcode_e op;

  assign op = opcode_e'(cmdData[OP_MSB:OP_LSB]);

  always_comb begin
    stb           = '0;
    nextState     = state;
    nextPendWrite = pendWrite;
    if (cmdValid) begin
      case (state)
        ST_ADDR: begin
          stb.memWr    = pendWrite;
          stb.memRd    = !pendWrite;
          stb.addrLoad = 1'b1;
          nextState    = ST_IDLE;
        end
        ST_CTL: begin
          stb.ctlWr = 1'b1;
          nextState = ST_IDLE;
        end
        default: begin
          case (op)
            OP_SELFG: stb.selFg = 1'b1;
            OP_SELBG: stb.selBg = 1'b1;
            OP_WRCTL: nextState = ST_CTL;
            OP_RDCTL: stb.ctlRd = 1'b1;
            OP_WRMEM, OP_RDMEM: begin
              if (cmdData[ADDR_FLAG]) begin
                nextState     = ST_ADDR;
                nextPendWrite = (op == OP_WRMEM);
              end else begin
                stb.memWr = (op == OP_WRMEM);
                stb.memRd = (op == OP_RDMEM);
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendWrite <= 1'b0;
    end else begin
      state     <= nextState;
      pendWrite <= nextPendWrite;
    end
  end

endmodule

// File: rtl/cmd_front_dpath.sv
module cmd_front_dpath
  import cmd_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cmdData,
  input  strobe_t           stb,
  output logic              memWr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              cmpReq,
  output logic              softRst,
  output logic              activeBank,
  output logic [15:0]       activeCtl,
  output logic [ADDR_W-1:0] activeAddr
);

  localparam int NUM_BANKS = 2;

  logic [CTL_W-1:0]  ctlBank  [NUM_BANKS];
  logic [ADDR_W-1:0] addrBank [NUM_BANKS];
  logic              bankSel;
  logic              doReset, doCtlStore, doAccess;
  logic [ADDR_W-1:0] accAddr, nextAddr;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode);
    case (mode)
      2'b01:   return a + ADDR_W'(1);
      2'b10:   return a - ADDR_W'(1);
      default: return a;
    endcase
  endfunction

  assign doReset    = stb.ctlWr && !cmdData[15];
  assign doCtlStore = stb.ctlWr && cmdData[15];
  assign doAccess   = stb.memWr || stb.memRd;
  assign accAddr    = stb.addrLoad ? cmdData[ADDR_W-1:0] : addrBank[bankSel];
  assign nextAddr   = stepAddr(accAddr, ctlBank[bankSel][3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN || doReset) begin
        ctlBank[b]  <= '0;
        addrBank[b] <= '0;
      end else if (bankSel == 1'(b)) begin
        if (doCtlStore) ctlBank[b]  <= cmdData[CTL_W-1:0];
        if (doAccess)   addrBank[b] <= nextAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel <= 1'b0;
      memWr   <= 1'b0;
      memRd   <= 1'b0;
      memAddr <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      cmpReq  <= 1'b0;
      softRst <= 1'b0;
    end else begin
      memWr   <= stb.memWr;
      memRd   <= stb.memRd;
      rdValid <= stb.ctlRd;
      cmpReq  <= doCtlStore;
      softRst <= doReset;
      if (doAccess)  memAddr <= accAddr;
      if (stb.ctlRd) rdData  <= {1'b0, ctlBank[bankSel]};
      if (doReset)        bankSel <= 1'b0;
      else if (stb.selFg) bankSel <= 1'b0;
      else if (stb.selBg) bankSel <= 1'b1;
    end
  end

  assign activeBank = bankSel;
  assign activeCtl  = {1'b0, ctlBank[bankSel]};
  assign activeAddr = addrBank[bankSel];

endmodule

// File: rtl/cmd_front.sv
module cmd_front
  import cmd_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [15:0]       cmdData,
  output logic              memWr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              cmpReq,
  output logic              softRst,
  output logic              activeBank,
  output logic [15:0]       activeCtl,
  output logic [ADDR_W-1:0] activeAddr
);

  strobe_t stb;

  cmd_front_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .stb      (stb)
  );

  cmd_front_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .cmdData    (cmdData),
    .stb        (stb),
    .memWr      (memWr),
    .memRd      (memRd),
    .memAddr    (memAddr),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .cmpReq     (cmpReq),
    .softRst    (softRst),
    .activeBank (activeBank),
    .activeCtl  (activeCtl),
    .activeAddr (activeAddr)
  );

endmodule

// File: rtl/cmd_front_chk.sv
module cmd_front_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              memWr,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rdValid,
  input logic [15:0]       rdData,
  input logic              cmpReq,
  input logic              softRst,
  input logic              activeBank,
  input logic [15:0]       activeCtl,
  input logic [ADDR_W-1:0] activeAddr
);

  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWr, memRd, rdValid, cmpReq, softRst}));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !(memWr || memRd || rdValid || cmpReq || softRst));

  assert_reset_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (activeBank == 1'b0 && activeCtl == 16'h0 && activeAddr == '0));

  assert_readback_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[15] == 1'b0 && rdData == activeCtl));

  assert_step_inc_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((memWr || memRd) && activeCtl[3:2] == 2'b01) |-> activeAddr == memAddr + ADDR_W'(1));

  assert_step_dec_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((memWr || memRd) && activeCtl[3:2] == 2'b10) |-> activeAddr == memAddr - ADDR_W'(1));

  assert_step_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((memWr || memRd) && activeCtl[3] == activeCtl[2]) |-> activeAddr == memAddr);

endmodule

bind cmd_front cmd_front_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .memWr      (memWr),
  .memRd      (memRd),
  .memAddr    (memAddr),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .cmpReq     (cmpReq),
  .softRst    (softRst),
  .activeBank (activeBank),
  .activeCtl  (activeCtl),
  .activeAddr (activeAddr)
);

// File: tb/tb_cmd_front.sv
`timescale 1ns/1ps
module tb_cmd_front;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [15:0]   cmdData = '0;
  logic          memWr, memRd, rdValid, cmpReq, softRst, activeBank;
  logic [AW-1:0] memAddr, activeAddr;
  logic [15:0]   rdData, activeCtl;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_front #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .memWr(memWr), .memRd(memRd), .memAddr(memAddr), .rdValid(rdValid),
    .rdData(rdData), .cmpReq(cmpReq), .softRst(softRst),
    .activeBank(activeBank), .activeCtl(activeCtl), .activeAddr(activeAddr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    cmdValid = 1'b1;
    cmdData  = w;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdData  = 16'hA5A5;
  endtask

  function automatic int stepped(input int a, input int mode);
    if (mode == 1) return (a + 1) % DEPTH;
    if (mode == 2) return (a + DEPTH - 1) % DEPTH;
    return a;
  endfunction

  function automatic int strobes();
    return {27'd0, memWr, memRd, rdValid, cmpReq, softRst};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bank", activeBank, 0);
    check("R1 ctl", activeCtl, 0);
    check("R1 addr", activeAddr, 0);
    check("R1 strobes", strobes(), 0);

    // Sweep: every step mode against every load value (foreground bank)
    for (int mode = 0; mode < 4; mode++) begin
      issue(16'h3000);
      check("R3 no pulse on opcode word", strobes(), 0);
      issue(16'h8000 | 16'(mode << 2));
      check("R3 cmpReq", cmpReq, 1);
      check("R3 stored", activeCtl, mode << 2);
      for (int ld = 0; ld < DEPTH; ld++) begin
        issue(16'h5800);
        check("R7 no strobe on flagged word", strobes(), 0);
        issue(16'h2000 | 16'(ld));
        check("R7 memWr", memWr, 1);
        check("R7 memAddr", memAddr, ld);
        check("R2 opcode-like address word not decoded", activeBank, 0);
        check("R8 step after load", activeAddr, stepped(ld, mode));
        issue(16'h6000);
        check("R9 decoded again", memRd, 1);
        check("R6 addr", memAddr, stepped(ld, mode));
        check("R8 second step", activeAddr, stepped(stepped(ld, mode), mode));
      end
    end
    // flagged read
    issue(16'h6800);
    issue(16'h0007);
    check("R7 memRd", memRd, 1);
    check("R7 memWr low", memWr, 0);
    check("R7 rd addr", memAddr, 7);

    // Bank switching: foreground holds ctl 0x000C, addr 7
    issue(16'h2000);
    check("R2 bg", activeBank, 1);
    check("R3 bg ctl untouched", activeCtl, 0);
    check("R2 bg addr", activeAddr, 0);
    issue(16'h3000); issue(16'h8004);
    issue(16'h5000);
    check("R6 bg write addr", memAddr, 0);
    check("R8 bg inc", activeAddr, 1);
    issue(16'h4000);
    check("R5 rdValid", rdValid, 1);
    check("R5 rdData", rdData, 16'h0004);
    issue(16'h1000);
    check("R2 fg", activeBank, 0);
    check("R3 fg ctl kept", activeCtl, 16'h000C);
    check("R2 fg addr kept", activeAddr, 7);
    issue(16'h3000); issue(16'hFFF1);
    issue(16'h4800);
    check("R5 bit15 reads 0", rdData, 16'h7FF1);
    check("R10 bit11 on read-ctl single cycle", rdValid, 1);

    // Ignored opcodes and idle cycles
    for (int op = 7; op < 16; op++) begin
      issue(16'(op << 12) | 16'h0ABC);
      check("R10 unused opcode strobes", strobes(), 0);
      check("R10 unused opcode ctl", activeCtl, 16'h7FF1);
      check("R10 unused opcode bank", activeBank, 0);
    end
    issue(16'h0000);
    check("R10 nop", strobes(), 0);
    cmdData = 16'h2000;
    @(negedge clk);
    check("R10 idle select ignored", activeBank, 0);
    check("R10 idle strobes", strobes(), 0);
    issue(16'h2800);
    check("R10 bit11 on select", activeBank, 1);
    issue(16'h6000);
    check("R10 next word decoded", memRd, 1);
    check("R10 bg addr used", memAddr, 1);

    // Soft reset from the background bank
    issue(16'h3000);
    issue(16'h7FFF);
    check("R4 softRst", softRst, 1);
    check("R4 no cmpReq", cmpReq, 0);
    check("R4 bank", activeBank, 0);
    check("R4 fg ctl", activeCtl, 0);
    check("R4 fg addr", activeAddr, 0);
    issue(16'h2000);
    check("R4 bg ctl", activeCtl, 0);
    check("R4 bg addr", activeAddr, 0);
    issue(16'h5000);
    check("R4 decoder idle", memWr, 1);
    check("R4 hold after reset", activeAddr, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule